// File: doc/BRIEF.md
# Skip-Group Condition Evaluator

This block decides whether a skip-class instruction of an 18-bit ones'-complement accumulator machine should skip the next word. It takes one instruction word and a snapshot of the operands the instruction can test: the accumulator, the in-out register, the overflow flag, six program flags and six sense switches. It returns two results. The first is a skip decision, which the sequencer uses to advance the program counter by one extra word. The second is a strobe that tells the sequencer to clear the overflow flag.

Each condition bit in the word selects one test. When several bits are set, the word skips if any of the selected tests holds. The indirect bit inverts the final decision. A word with no condition bits and the indirect bit set therefore always skips.

The operands enter on a valid/ready channel together with the word. The result leaves on a second valid/ready channel one cycle after the word is accepted. A new word is accepted whenever the output slot is empty or is being drained in the same cycle, so `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no input is taken. Word bits are numbered from 0 at the least significant end. The octal values below are values of the 18-bit word.

Top module: `sk_skip_eval`

## Requirements
- R1: Only words with bits 17..13 equal to binary 11010 are evaluated. In octal, these are words of the form 64xxxx, or 65xxxx when the indirect bit is set. Any other word yields skip 0 and overflow-clear 0. Bit 11 (octal 004000) has no effect.
- R2: Bit 8 (octal 000400) holds when AC bit 17 is 1. Bit 7 (octal 000200) holds when AC bit 17 is 0.
- R3: Bit 6 (octal 000100) holds only when AC is all zeros. An AC of all ones (minus zero) does not satisfy it.
- R4: Bit 10 (octal 002000) holds when IO bit 17 is 0.
- R5: Bit 9 (octal 001000) holds when the overflow input is 0. For an evaluated word, overflow-clear equals bit 9, whatever the skip outcome.
- R6: Bits 2..0 are a flag field. A value n from 1 to 6 holds when flag n-1 is 0. The value 7 holds only when all six flags are 0. The value 0 selects no flag test.
- R7: Bits 5..3 are a sense-switch field. It works like the flag field, but on the six sense switches.
- R8: When several tests are selected, the condition is their inclusive OR.
- R9: Bit 12 (octal 010000), the indirect bit, inverts the condition. With no test selected and bit 12 set, the word skips.
- R10: A word is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold their values.
- R11: During reset and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word and operands are presented |
| in_ready | output | 1 | Block can take a word this cycle |
| in_instr | input | 18 | Instruction word |
| in_ac | input | 18 | Accumulator value |
| in_io | input | 18 | In-out register value |
| in_ovf | input | 1 | Overflow flag |
| in_flags | input | 6 | Program flags, flag 1 in bit 0 |
| in_sense | input | 6 | Sense switches, switch 1 in bit 0 |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_skip | output | 1 | Skip the next word |
| out_ovf_clr | output | 1 | Clear the overflow flag |

## Verification
Each accumulator test is driven with a negative value, a small positive value, plus zero and minus zero. These values separate a sign test from a magnitude test and show that the zero test rejects minus zero. The flag and switch fields are driven three ways: with the addressed bit set, with only a neighbouring bit set, and with the all-bits selector. These patterns expose an off-by-one index or a test that swaps "any" and "all". Combined words, indirect words and words with foreign opcodes show the OR, the inversion and the decode gate. A stalled consumer shows that the result holds and that no input is taken.

// File: rtl/sk_pkg.sv
package sk_pkg;
  localparam int WORD_W   = 18;
  localparam int SEL_N    = 6;
  localparam int FLD_W    = 3;
  localparam int OPC_W    = 5;
  localparam int OPC_LSB  = WORD_W - OPC_W;
  localparam logic [OPC_W-1:0] OPC_SKIP = 5'b11010;
  localparam int IND_BIT  = 12;
  localparam int RSV_BIT  = 11;
  localparam int IOP_BIT  = 10;
  localparam int OVZ_BIT  = 9;
  localparam int NEG_BIT  = 8;
  localparam int POS_BIT  = 7;
  localparam int ZER_BIT  = 6;
  localparam int SW_LSB   = FLD_W;
  localparam int FL_LSB   = 0;

  typedef struct packed {
    logic skip;
    logic ovf_clr;
  } sk_res_t;
endpackage

// File: rtl/sk_field_test.sv
module sk_field_test #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [W-1:0] sel,
  input  logic [N-1:0] bits,
  output logic         hit
);
  localparam logic [W-1:0] ALL = {W{1'b1}};

  logic [N-1:0] one_hit;

  for (genvar k = 0; k < N; k++) begin : g_sel
    localparam logic [W-1:0] CODE = W'(k + 1);
    assign one_hit[k] = (sel == CODE) && !bits[k];
  end

  assign hit = (|one_hit) || ((sel == ALL) && (bits == '0));
endmodule

// File: rtl/sk_cond_eval.sv
module sk_cond_eval
  import sk_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] ac,
  input  logic              io_sign,
  input  logic              ovf,
  input  logic [SEL_N-1:0]  flags,
  input  logic [SEL_N-1:0]  sense,
  output sk_res_t           res
);
  logic is_skip_op;
  logic flag_hit;
  logic sw_hit;
  logic cond;
  logic unused_rsv;

  assign unused_rsv = instr[RSV_BIT];
  assign is_skip_op = (instr[WORD_W-1:OPC_LSB] == OPC_SKIP);

  sk_field_test #(.N(SEL_N), .W(FLD_W)) u_flag (
    .sel  (instr[FL_LSB +: FLD_W]),
    .bits (flags),
    .hit  (flag_hit)
  );

  sk_field_test #(.N(SEL_N), .W(FLD_W)) u_sw (
    .sel  (instr[SW_LSB +: FLD_W]),
    .bits (sense),
    .hit  (sw_hit)
  );

  always_comb begin
    cond = 1'b0;
    if (instr[NEG_BIT] &&  ac[WORD_W-1]) cond = 1'b1;
    if (instr[POS_BIT] && !ac[WORD_W-1]) cond = 1'b1;
    if (instr[ZER_BIT] && (ac == '0))    cond = 1'b1;
    if (instr[IOP_BIT] && !io_sign)      cond = 1'b1;
    if (instr[OVZ_BIT] && !ovf)          cond = 1'b1;
    if (flag_hit || sw_hit)              cond = 1'b1;
    res.skip    = is_skip_op && (cond ^ instr[IND_BIT]);
    res.ovf_clr = is_skip_op && instr[OVZ_BIT];
  end
endmodule

// File: rtl/sk_out_stage.sv
module sk_out_stage
  import sk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  sk_res_t d,
  input  logic    drain,
  output logic    valid,
  output sk_res_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      if (take) begin
        valid <= 1'b1;
        q     <= d;
      end else if (drain) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sk_skip_eval.sv
module sk_skip_eval
  import sk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_instr,
  input  logic [WORD_W-1:0] in_ac,
  input  logic [WORD_W-1:0] in_io,
  input  logic              in_ovf,
  input  logic [SEL_N-1:0]  in_flags,
  input  logic [SEL_N-1:0]  in_sense,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_skip,
  output logic              out_ovf_clr
);
  sk_res_t comb_res;
  sk_res_t held_res;
  logic    take;
  logic    unused_io_low;

  assign unused_io_low = ^in_io[WORD_W-2:0];
  assign in_ready      = !out_valid || out_ready;
  assign take          = in_valid && in_ready;

  sk_cond_eval u_eval (
    .instr   (in_instr),
    .ac      (in_ac),
    .io_sign (in_io[WORD_W-1]),
    .ovf     (in_ovf),
    .flags   (in_flags),
    .sense   (in_sense),
    .res     (comb_res)
  );

  sk_out_stage u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .d     (comb_res),
    .drain (out_ready),
    .valid (out_valid),
    .q     (held_res)
  );

  assign out_skip    = held_res.skip;
  assign out_ovf_clr = held_res.ovf_clr;
endmodule

// File: rtl/sk_skip_eval_chk.sv
module sk_skip_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [17:0] in_instr,
  input logic [17:0] in_ac,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_skip,
  input logic        out_ovf_clr
);
  logic acc;
  logic op_ok;
  assign acc   = in_valid && in_ready;
  assign op_ok = (in_instr[17:13] == 5'b11010);

  p_reset_r11: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_skip) && $stable(out_ovf_clr)));

  p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_ok) |=> (!out_skip && !out_ovf_clr));

  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_ok) |=> (out_ovf_clr == $past(in_instr[9])));

  p_plus_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_ok && in_instr[12:6] == 7'b0000001 && in_instr[5:0] == 6'd0)
      |=> (out_skip == ($past(in_ac) == 18'd0)));
endmodule

bind sk_skip_eval sk_skip_eval_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .in_ac       (in_ac),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_skip    (out_skip),
  .out_ovf_clr (out_ovf_clr)
);

// File: tb/sim_sk_skip_eval.sv
module sim_sk_skip_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_instr = '0;
  logic [17:0] in_ac = '0;
  logic [17:0] in_io = '0;
  logic        in_ovf = 1'b0;
  logic [5:0]  in_flags = '0;
  logic [5:0]  in_sense = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_skip;
  logic        out_ovf_clr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sk_skip_eval u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_ac(in_ac), .in_io(in_io), .in_ovf(in_ovf),
    .in_flags(in_flags), .in_sense(in_sense), .out_valid(out_valid),
    .out_ready(out_ready), .out_skip(out_skip), .out_ovf_clr(out_ovf_clr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic eval(input string req, input logic [17:0] w, input logic [17:0] ac,
                      input logic [17:0] io, input logic ovf, input logic [5:0] fl,
                      input logic [5:0] sw, input logic exp_skip, input logic exp_clr);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_ac = ac; in_io = io;
    in_ovf = ovf; in_flags = fl; in_sense = sw;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, out_valid, 1'b1);
    chk({req, " skip"}, out_skip, exp_skip);
    chk({req, " ovf_clr"}, out_ovf_clr, exp_clr);
  endtask

  task automatic t_reset_r11();
    chk("R11 out_valid in reset", out_valid, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", out_valid, 1'b0);
    chk("R10 ready when empty", in_ready, 1'b1);
  endtask

  task automatic t_sign_r2();
    eval("R2 neg on neg AC", 18'o640400, 18'o400000, 0, 1, 0, 0, 1, 0);
    eval("R2 neg on pos AC", 18'o640400, 18'o000001, 0, 1, 0, 0, 0, 0);
    eval("R2 pos on pos AC", 18'o640200, 18'o000001, 0, 1, 0, 0, 1, 0);
    eval("R2 pos on neg AC", 18'o640200, 18'o777777, 0, 1, 0, 0, 0, 0);
    eval("R2 pos on zero AC", 18'o640200, 18'o000000, 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_zero_r3();
    eval("R3 plus zero", 18'o640100, 18'o000000, 0, 1, 0, 0, 1, 0);
    eval("R3 minus zero", 18'o640100, 18'o777777, 0, 1, 0, 0, 0, 0);
    eval("R3 nonzero", 18'o640100, 18'o000004, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_io_r4();
    eval("R4 pos IO", 18'o642000, 0, 18'o377777, 1, 0, 0, 1, 0);
    eval("R4 neg IO", 18'o642000, 0, 18'o400000, 1, 0, 0, 0, 0);
  endtask

  task automatic t_ovf_r5();
    eval("R5 ovf clear", 18'o641000, 0, 0, 0, 0, 0, 1, 1);
    eval("R5 ovf set", 18'o641000, 0, 0, 1, 0, 0, 0, 1);
    eval("R5 ovf set inverted", 18'o651000, 0, 0, 1, 0, 0, 1, 1);
  endtask

  task automatic t_flags_r6();
    eval("R6 flag3 clear", 18'o640003, 0, 0, 1, 6'b111011, 0, 1, 0);
    eval("R6 flag3 set", 18'o640003, 0, 0, 1, 6'b000100, 0, 0, 0);
    eval("R6 flag6 set", 18'o640006, 0, 0, 1, 6'b100000, 0, 0, 0);
    eval("R6 all flags clear", 18'o640007, 0, 0, 1, 6'b000000, 0, 1, 0);
    eval("R6 all one flag set", 18'o640007, 0, 0, 1, 6'b100000, 0, 0, 0);
    eval("R6 field zero", 18'o640000, 0, 0, 1, 6'b000000, 0, 0, 0);
  endtask

  task automatic t_sense_r7();
    eval("R7 sw3 set", 18'o640030, 0, 0, 1, 0, 6'b000100, 0, 0);
    eval("R7 sw3 clear", 18'o640030, 0, 0, 1, 0, 6'b111011, 1, 0);
    eval("R7 sw1 clear", 18'o640010, 0, 0, 1, 0, 6'b111110, 1, 0);
    eval("R7 all clear", 18'o640070, 0, 0, 1, 0, 6'b000000, 1, 0);
    eval("R7 all one set", 18'o640070, 0, 0, 1, 0, 6'b000001, 0, 0);
  endtask

  task automatic t_union_r8();
    eval("R8 neg|pos", 18'o640600, 18'o123456, 0, 1, 0, 0, 1, 0);
    eval("R8 neg|zero on pos", 18'o640500, 18'o000001, 0, 1, 0, 0, 0, 0);
    eval("R8 neg|zero on zero", 18'o640500, 18'o000000, 0, 1, 0, 0, 1, 0);
    eval("R8 flag|io one true", 18'o642001, 0, 18'o400000, 1, 6'b000000, 0, 1, 0);
  endtask

  task automatic t_invert_r9();
    eval("R9 inv neg on neg", 18'o650400, 18'o400000, 0, 1, 0, 0, 0, 0);
    eval("R9 inv neg on pos", 18'o650400, 18'o000001, 0, 1, 0, 0, 1, 0);
    eval("R9 inv no test", 18'o650000, 0, 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_decode_r1();
    eval("R1 foreign op", 18'o600400, 18'o400000, 0, 0, 0, 0, 0, 0);
    eval("R1 foreign ovf bit", 18'o661000, 0, 0, 0, 0, 0, 0, 0);
    eval("R1 foreign inv", 18'o670000, 0, 0, 0, 0, 0, 0, 0);
    eval("R1 bit11 ignored", 18'o644400, 18'o000001, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_stall_r10();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = 18'o650000; in_ac = 0; in_ovf = 1'b1;
    in_flags = 0; in_sense = 0;
    @(negedge clk);
    in_instr = 18'o641000; in_ovf = 1'b1;
    chk("R10 valid after take", out_valid, 1'b1);
    chk("R10 ready low in stall", in_ready, 1'b0);
    chk("R10 first result", out_skip, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R10 held skip", out_skip, 1'b1);
    chk("R10 held clr", out_ovf_clr, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second valid", out_valid, 1'b1);
    chk("R10 second skip", out_skip, 1'b0);
    chk("R10 second clr", out_ovf_clr, 1'b1);
    @(negedge clk);
    chk("R10 drained", out_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r11();
    t_sign_r2();
    t_zero_r3();
    t_io_r4();
    t_ovf_r5();
    t_flags_r6();
    t_sense_r7();
    t_union_r8();
    t_invert_r9();
    t_decode_r1();
    t_stall_r10();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule